// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a load-store RISC core. Each cycle it accepts an operation code with a valid strobe. Its operands are either two register values or one register value plus a 16-bit immediate. One clock edge later it presents a 32-bit result, an overflow-exception flag and a write-enable for the destination register.

Signed add and signed subtract trap on two's-complement overflow: the flag rises and the write-enable stays low, so the destination keeps its old value. The unsigned forms wrap modulo 2^32 and never trap. The block extends the immediate itself. Arithmetic operations sign-extend it. The logical operations zero-extend it. Load-upper-immediate moves it into the top half of the word.

Operand selection works as follows. With `use_imm_i` high the second operand is the extended immediate; otherwise it is `rt_i`. Shifts always act on `rt_i`, and the shift amount is always taken from `shamt_i`.

Top module: `alu_exec`

## Requirements
- R1: While `rst_ni` is low, and after it until the first accepted operation, `result_o`, `ovf_o` and `wr_en_o` are all zero.
- R2: Outputs are registered. An operation presented while `valid_i` is high appears on the outputs after the next rising clock edge, and the outputs do not change before that edge.
- R3: Signed add (code 0) and signed subtract (code 2) set `ovf_o` and clear `wr_en_o` exactly when the true signed result does not fit in 32 bits. `result_o` still shows the wrapped value. Adding two values of opposite sign never sets `ovf_o`.
- R4: Unsigned add (code 1) and unsigned subtract (code 3) return the sum or difference modulo 2^32, never set `ovf_o`, and always raise `wr_en_o`.
- R5: When `use_imm_i` is high, codes 0 to 3 use the 16-bit immediate sign-extended to 32 bits as the second operand.
- R6: When `use_imm_i` is high, the logical codes AND (4), OR (5) and XOR (6) use the immediate zero-extended to 32 bits.
- R7: Codes 8, 9 and 10 shift `rt_i` by `shamt_i` (0 to 31): 8 shifts left filling zeros, 9 shifts right filling zeros, and 10 shifts right filling with bit 31 of `rt_i`.
- R8: Code 11 (load upper immediate) returns the immediate in bits [31:16] and zeros in bits [15:0], with `wr_en_o` high.
- R9: `wr_en_o` is high only for a valid, defined, non-overflowing operation. When `valid_i` is low, the next cycle shows all outputs zero.
- R10: Codes 12 to 15 are undefined. They give a zero result, `ovf_o` low and `wr_en_o` low.
- R11: With `use_imm_i` low, codes 4, 5, 6 and 7 return the bitwise AND, OR, XOR and NOR of `rs_i` and `rt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| use_imm_i | input | 1 | Second operand is the extended immediate |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand / shift source |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Shift amount |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Signed-overflow exception |
| wr_en_o | output | 1 | Destination register write-enable |

## Verification
The bench builds the block with its default widths: a 32-bit datapath, a 16-bit immediate and a 5-bit shift amount. At these widths the exact overflow edges can be driven directly, for example 0x7FFFFFFF plus one and 0x80000000 minus one. The sign bit of a 16-bit immediate can be set to separate sign extension from zero extension. Shift amounts 0 and 31 are reached, which exercise every stage of the barrel shifter. Random operation codes include the undefined codes 12 to 15, and the random stimulus also contains idle cycles.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10,
        OP_LUI  = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm_i,
    input  logic             sign_ext_i,
    output logic [XLEN-1:0]  ext_o
);
    localparam int PAD_W = XLEN - IMM_W;

    logic fill;

    always_comb begin
        fill  = sign_ext_i & imm_i[IMM_W-1];
        ext_o = {{PAD_W{fill}}, imm_i};
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    output logic [XLEN-1:0] sum_o,
    output logic            sovf_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] cin;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        cin    = {{(XLEN-1){1'b0}}, sub_i};
        sum_o  = a_i + b_eff + cin;
        // operands agree in sign, result disagrees
        sovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic_fn_e       fn_i,
    output logic [XLEN-1:0] res_o
);
    always_comb begin
        unique case (fn_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            LG_NOR:  res_o = ~(a_i | b_i);
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            left_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] res_o
);
    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] rev_out;
    logic [XLEN-1:0] stg [0:SHW];
    logic            fill;

    // bit reversal lets one right-shifting network also shift left
    for (genvar i = 0; i < XLEN; i++) begin : g_rev
        assign rev_in[i]  = val_i[XLEN-1-i];
        assign rev_out[i] = stg[SHW][XLEN-1-i];
    end

    assign fill   = arith_i & ~left_i & val_i[XLEN-1];
    assign stg[0] = left_i ? rev_in : val_i;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
    end

    assign res_o = left_i ? rev_out : stg[SHW];
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SHW   = $clog2(XLEN)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic [3:0]       op_i,
    input  logic             use_imm_i,
    input  logic [XLEN-1:0]  rs_i,
    input  logic [XLEN-1:0]  rt_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [SHW-1:0]   shamt_i,
    output logic [XLEN-1:0]  result_o,
    output logic             ovf_o,
    output logic             wr_en_o
);
    localparam int LOW_W = XLEN - IMM_W;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            ovf;
        logic            wr_en;
    } stage_t;

    stage_t stage_d, stage_q;

    alu_op_e         op;
    logic            is_arith;
    logic            is_sub;
    logic            is_signed;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] sum;
    logic            sovf;
    logic [XLEN-1:0] lg_res;
    logic [XLEN-1:0] sh_res;
    logic_fn_e       lg_fn;

    always_comb begin
        op        = alu_op_e'(op_i);
        is_arith  = (op == OP_ADD) || (op == OP_ADDU) || (op == OP_SUB) || (op == OP_SUBU);
        is_sub    = (op == OP_SUB) || (op == OP_SUBU);
        is_signed = (op == OP_ADD) || (op == OP_SUB);
        opnd_b    = use_imm_i ? imm_ext : rt_i;
        unique case (op)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            OP_NOR:  lg_fn = LG_NOR;
            default: lg_fn = LG_AND;
        endcase
    end

    alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
        .imm_i      (imm_i),
        .sign_ext_i (is_arith),
        .ext_o      (imm_ext)
    );

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a_i    (rs_i),
        .b_i    (opnd_b),
        .sub_i  (is_sub),
        .sum_o  (sum),
        .sovf_o (sovf)
    );

    alu_logic #(.XLEN(XLEN)) u_logic (
        .a_i   (rs_i),
        .b_i   (opnd_b),
        .fn_i  (lg_fn),
        .res_o (lg_res)
    );

    alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .val_i   (rt_i),
        .amt_i   (shamt_i),
        .left_i  (op == OP_SLL),
        .arith_i (op == OP_SRA),
        .res_o   (sh_res)
    );

    always_comb begin
        stage_d = '0;
        if (valid_i) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    stage_d.result = sum;
                    stage_d.ovf    = sovf;
                    stage_d.wr_en  = ~sovf;
                end
                OP_ADDU, OP_SUBU: begin
                    stage_d.result = sum;
                    stage_d.wr_en  = 1'b1;
                end
                OP_AND, OP_OR, OP_XOR, OP_NOR: begin
                    stage_d.result = lg_res;
                    stage_d.wr_en  = 1'b1;
                end
                OP_SLL, OP_SRL, OP_SRA: begin
                    stage_d.result = sh_res;
                    stage_d.wr_en  = 1'b1;
                end
                OP_LUI: begin
                    stage_d.result = {imm_i, {LOW_W{1'b0}}};
                    stage_d.wr_en  = 1'b1;
                end
                default: stage_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= stage_d;
    end

    assign result_o = stage_q.result;
    assign ovf_o    = stage_q.ovf;
    assign wr_en_o  = stage_q.wr_en;

    logic unused_signed;
    assign unused_signed = is_signed;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int SHW   = $clog2(XLEN)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             valid_i,
    input logic [3:0]       op_i,
    input logic             use_imm_i,
    input logic [XLEN-1:0]  rs_i,
    input logic [XLEN-1:0]  rt_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [SHW-1:0]   shamt_i,
    input logic [XLEN-1:0]  result_o,
    input logic             ovf_o,
    input logic             wr_en_o
);
    localparam int LOW_W = XLEN - IMM_W;

    // R3
    mixed_sign_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_ADD && !use_imm_i && rs_i[XLEN-1] != rt_i[XLEN-1]) |=> !ovf_o);

    // R4
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && (op_i == OP_ADDU || op_i == OP_SUBU)) |=> (!ovf_o && wr_en_o));

    // R7
    sra_sign_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_SRA && rt_i[XLEN-1]) |=> result_o[XLEN-1]);

    // R8
    lui_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == OP_LUI) |=> (result_o[LOW_W-1:0] == '0 && wr_en_o));

    // R9
    trap_blocks_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> !wr_en_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!wr_en_o && !ovf_o && result_o == '0));

    // R10
    undef_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i > OP_LUI) |=> (result_o == '0 && !wr_en_o && !ovf_o));

    logic unused_ok;
    assign unused_ok = ^{imm_i, shamt_i, rs_i[XLEN-2:0], rt_i[XLEN-2:0]};
endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .SHW(SHW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .use_imm_i (use_imm_i),
    .rs_i      (rs_i),
    .rt_i      (rt_i),
    .imm_i     (imm_i),
    .shamt_i   (shamt_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o),
    .wr_en_o   (wr_en_o)
);

// File: tb/alu_exec_bench.sv
`timescale 1ns/1ps
module alu_exec_bench;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [3:0]  op = '0;
    logic        use_imm = 1'b0;
    logic [31:0] rs = '0, rt = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        ovf, wr_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    alu_exec u_alu_exec (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
        .use_imm_i(use_imm), .rs_i(rs), .rt_i(rt), .imm_i(imm),
        .shamt_i(shamt), .result_o(result), .ovf_o(ovf), .wr_en_o(wr_en)
    );

    task automatic check(input string req, input logic [31:0] r, input logic o, input logic w,
                         input logic [31:0] er, input logic eo, input logic ew);
        checks++;
        if (r !== er || o !== eo || w !== ew) begin
            fails++;
            $display("FAIL %s: got res=%h ovf=%b wr=%b, expected res=%h ovf=%b wr=%b",
                     req, r, o, w, er, eo, ew);
        end
    endtask

    function automatic string req_of(input logic v, input logic [3:0] c, input logic ui);
        if (!v) return "R9";
        if (c > 4'd11) return "R10";
        if (c == 4'd11) return "R8";
        if (c >= 4'd8) return "R7";
        if (c >= 4'd4) return ui ? "R6" : "R11";
        if (ui) return "R5";
        return (c == 4'd0 || c == 4'd2) ? "R3" : "R4";
    endfunction

    task automatic model(input logic v, input logic [3:0] c, input logic ui,
                         input logic [31:0] a, input logic [31:0] t, input logic [15:0] im,
                         input logic [4:0] sh, output logic [31:0] r, output logic o,
                         output logic w);
        logic [31:0] b;
        longint s;
        r = '0; o = 1'b0; w = 1'b0;
        if (!v) return;
        if (c <= 4'd3) b = ui ? {{16{im[15]}}, im} : t;
        else           b = ui ? {16'h0, im} : t;
        w = 1'b1;
        case (c)
            4'd0, 4'd2: begin
                s = (c == 4'd0) ? longint'($signed(a)) + longint'($signed(b))
                                : longint'($signed(a)) - longint'($signed(b));
                r = s[31:0];
                o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                w = ~o;
            end
            4'd1:  r = a + b;
            4'd3:  r = a - b;
            4'd4:  r = a & b;
            4'd5:  r = a | b;
            4'd6:  r = a ^ b;
            4'd7:  r = ~(a | b);
            4'd8:  r = t << sh;
            4'd9:  r = t >> sh;
            4'd10: r = $unsigned($signed(t) >>> sh);
            4'd11: r = {im, 16'h0};
            default: begin r = '0; w = 1'b0; end
        endcase
    endtask

    // drive at a falling edge, check at the next falling edge (one register in between)
    task automatic run(input logic v, input logic [3:0] c, input logic ui, input logic [31:0] a,
                       input logic [31:0] t, input logic [15:0] im, input logic [4:0] sh);
        logic [31:0] er; logic eo, ew;
        valid = v; op = c; use_imm = ui; rs = a; rt = t; imm = im; shamt = sh;
        model(v, c, ui, a, t, im, sh, er, eo, ew);
        @(negedge clk);
        check(req_of(v, c, ui), result, ovf, wr_en, er, eo, ew);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20ns * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] hold_r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset
        check("R1", result, ovf, wr_en, 32'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", result, ovf, wr_en, 32'h0, 1'b0, 1'b0);

        // R3 signed overflow corners
        run(1, 4'd0, 0, 32'h7FFF_FFFF, 32'h1,         16'h0, 5'd0);
        run(1, 4'd0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0);
        run(1, 4'd2, 0, 32'h8000_0000, 32'h1,         16'h0, 5'd0);
        run(1, 4'd2, 0, 32'h0,         32'h8000_0000, 16'h0, 5'd0);
        run(1, 4'd0, 0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0);
        // R4 unsigned wrap
        run(1, 4'd1, 0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        run(1, 4'd3, 0, 32'h0,         32'h1, 16'h0, 5'd0);
        // R5 sign-extended immediate
        run(1, 4'd0, 1, 32'h5, 32'h0, 16'h8000, 5'd0);
        run(1, 4'd0, 1, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
        // R6 zero-extended immediate
        run(1, 4'd5, 1, 32'h0, 32'h0, 16'h8000, 5'd0);
        run(1, 4'd4, 1, 32'hFFFF_FFFF, 32'h0, 16'hF0F0, 5'd0);
        // R11 register logic
        run(1, 4'd7, 0, 32'h0F0F_0000, 32'h0000_00FF, 16'h0, 5'd0);
        run(1, 4'd6, 0, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0);
        // R7 shifts at boundary amounts
        run(1, 4'd10, 0, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        run(1, 4'd9,  0, 32'h0, 32'h8000_0000, 16'h0, 5'd31);
        run(1, 4'd8,  0, 32'h0, 32'h1234_5678, 16'h0, 5'd0);
        run(1, 4'd8,  0, 32'h0, 32'h0000_0001, 16'h0, 5'd31);
        // R8 load upper immediate
        run(1, 4'd11, 1, 32'hFFFF_FFFF, 32'h0, 16'hABCD, 5'd0);
        // R10 undefined code
        run(1, 4'd13, 0, 32'h1, 32'h1, 16'h1, 5'd1);
        // R9 idle cycle
        run(0, 4'd1, 0, 32'h1, 32'h1, 16'h0, 5'd0);

        // R2: output holds until the edge after new inputs
        run(1, 4'd1, 0, 32'd40, 32'd2, 16'h0, 5'd0);
        hold_r = result;
        valid = 1'b1; op = 4'd1; use_imm = 1'b0; rs = 32'd7; rt = 32'd8;
        #5;
        check("R2", result, ovf, wr_en, hold_r, 1'b0, 1'b1);
        @(negedge clk);
        check("R2", result, ovf, wr_en, 32'd15, 1'b0, 1'b1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a, t;
            logic [3:0]  c;
            a = $urandom();
            t = $urandom();
            if ((i % 4) == 0) a = {a[31], {31{~a[31]}}};
            c = 4'($urandom_range(0, 15));
            run(($urandom_range(0, 9) != 0), c, 1'($urandom_range(0, 1)), a, t,
                16'($urandom()), 5'($urandom()));
        end
        finish_run();
    end
endmodule